// File: doc/BRIEF.md
# AVI InfoFrame Packet Builder

This block assembles the fixed-length auxiliary video information packet that an HDMI transmitter sends next to its video stream. A single start strobe captures the video identification code (VIC) and the output colour format. The block derives the colour-format, aspect-ratio and colorimetry fields from these two inputs. It then sums the seventeen packet bytes serially, one per cycle, to form a zero-sum checksum. After that it streams the bytes out in order, one per cycle, with a valid flag, a byte index and a closing done pulse.

The packet buffer is 17 bytes long. Index 0 holds the packet type, index 1 the version, index 2 the payload length and index 3 the checksum. Payload byte n sits at index 3+n. Downstream logic that places the packet into data islands takes the byte stream and writes each byte at its index.

Top module: `avi_pkt_builder`

## Requirements
- R1: While reset is held and in the first cycle after reset, `busy`, `outValid` and `done` are all low.
- R2: The bytes at indices 0, 1 and 2 are 0x82, 0x02 and 0x0D.
- R3: The byte at index 3 makes the 8-bit sum of all 17 emitted bytes equal to zero.
- R4: Index 4 carries the colour format in bits 6:5, coded as RGB=0, YCbCr 4:2:2=1 and YCbCr 4:4:4=2, and has bit 4 set and every other bit clear. `colorSel` uses the same codes, and `colorSel`=3 is treated as RGB.
- R5: For VIC 2, 6, 17 or 21 with a non-RGB format, index 5 equals 0x58: colorimetry code 1 (SMPTE 170M) in bits 7:6 and aspect code 1 (4:3) in bits 5:4.
- R6: For VIC 3, 7, 18 or 22 with a non-RGB format, index 5 equals 0x68: colorimetry 1 and aspect code 2 (16:9).
- R7: For any other VIC with a non-RGB format, index 5 equals 0xA8: colorimetry code 2 (BT.709) and aspect 2. The low nibble of index 5 is always 0x8.
- R8: When the format is RGB, the colorimetry bits of index 5 are 0 whatever the VIC, while the aspect bits still follow R5 to R7.
- R9: Index 7 equals the captured VIC. Index 6 and indices 8 to 16 are zero.
- R10: Start is sampled at a rising edge while idle. After that edge the block spends 17 cycles summing. It then raises `outValid` for 17 consecutive cycles, with `outIndex` running from 0 to 16.
- R11: `done` is high for exactly one cycle, the cycle after index 16. `busy` is low in the cycle that follows.
- R12: A start pulse while `busy` is high changes neither the packet in progress nor the captured inputs, and it does not cause a second packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request to build one packet; sampled only while idle |
| vic | input | 8 | Video identification code, captured at start |
| colorSel | input | 2 | Output colour format: 0 RGB, 1 YCbCr 4:2:2, 2 YCbCr 4:4:4, 3 RGB |
| busy | output | 1 | High from the cycle after an accepted start until the done cycle |
| outValid | output | 1 | High while a packet byte is presented |
| outIndex | output | 5 | Position of the presented byte in the packet |
| outByte | output | 8 | Presented byte; zero while `outValid` is low |
| done | output | 1 | One-cycle pulse after the last byte |

## Verification
The bench builds the block with its default 17-byte packet, so the full header, checksum and payload layout is reached on every run. This covers each of the eight SD codes on both aspect branches, every colour selector including the alias code 3, and random VICs that fall through to the high-definition default. Stray start pulses are injected while the block is summing and while it is emitting, which exercises the busy-ignore rule and the captured-input hold in both phases.

// File: rtl/avi_pkt_pkg.sv
package avi_pkt_pkg;
  localparam int BYTE_W = 8;

  localparam logic [BYTE_W-1:0] HDR_TYPE = 8'h82;
  localparam logic [BYTE_W-1:0] HDR_VER  = 8'h02;
  localparam logic [BYTE_W-1:0] HDR_LEN  = 8'h0D;

  typedef enum logic [1:0] {
    FMT_RGB    = 2'd0,
    FMT_YCC422 = 2'd1,
    FMT_YCC444 = 2'd2
  } fmt_e;

  typedef enum logic [1:0] {
    COLR_NONE   = 2'd0,
    COLR_SMPTE  = 2'd1,
    COLR_BT709  = 2'd2
  } colr_e;

  typedef enum logic [1:0] {
    ASP_NONE = 2'd0,
    ASP_4_3  = 2'd1,
    ASP_16_9 = 2'd2
  } asp_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;    // capture inputs, clear running sum
    logic accum;   // add byte at current index to running sum
    logic emit;    // present byte at current index
    logic finish;  // packet complete
  } ctrl_t;
endpackage

// File: rtl/avi_pkt_ctrl.sv
module avi_pkt_ctrl
  import avi_pkt_pkg::*;
#(
  parameter int PKT_BYTES = 17,
  parameter int IDX_W     = $clog2(PKT_BYTES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  output ctrl_t            ctrl,
  output logic [IDX_W-1:0] idx,
  output logic             busy
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(PKT_BYTES - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_SUM, ST_EMIT, ST_FIN} state_e;
  state_e state;
  logic [IDX_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          cnt <= '0;
          if (start) state <= ST_SUM;
        end
        ST_SUM: begin
          if (cnt == LAST) begin
            cnt   <= '0;
            state <= ST_EMIT;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_EMIT: begin
          if (cnt == LAST) begin
            cnt   <= '0;
            state <= ST_FIN;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_FIN: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    ctrl.load   = (state == ST_IDLE) && start;
    ctrl.accum  = (state == ST_SUM);
    ctrl.emit   = (state == ST_EMIT);
    ctrl.finish = (state == ST_FIN);
  end

  assign idx  = cnt;
  assign busy = (state != ST_IDLE);
endmodule

// File: rtl/avi_pkt_dp.sv
module avi_pkt_dp
  import avi_pkt_pkg::*;
#(
  parameter int PKT_BYTES = 17,
  parameter int IDX_W     = $clog2(PKT_BYTES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_t             ctrl,
  input  logic [IDX_W-1:0]  idx,
  input  logic [BYTE_W-1:0] vicIn,
  input  logic [1:0]        colorIn,
  output logic              outValid,
  output logic [IDX_W-1:0]  outIndex,
  output logic [BYTE_W-1:0] outByte,
  output logic              done
);
  localparam logic [IDX_W-1:0] IDX_CSUM = IDX_W'(3);
  localparam logic [IDX_W-1:0] IDX_PB1  = IDX_W'(4);
  localparam logic [IDX_W-1:0] IDX_PB2  = IDX_W'(5);
  localparam logic [IDX_W-1:0] IDX_VIC  = IDX_W'(7);

  logic [BYTE_W-1:0] vicReg;
  fmt_e              fmtReg;
  logic [BYTE_W-1:0] sumReg;

  fmt_e fmtIn;
  always_comb begin
    unique case (colorIn)
      2'd1:    fmtIn = FMT_YCC422;
      2'd2:    fmtIn = FMT_YCC444;
      default: fmtIn = FMT_RGB;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vicReg <= '0;
      fmtReg <= FMT_RGB;
      sumReg <= '0;
    end else if (ctrl.load) begin
      vicReg <= vicIn;
      fmtReg <= fmtIn;
      sumReg <= '0;
    end else if (ctrl.accum) begin
      sumReg <= sumReg + rawByte;
    end
  end

  // field derivation from captured VIC and format
  logic  sdWide, sdNarrow;
  asp_e  aspect;
  colr_e colr;
  logic [BYTE_W-1:0] pb1, pb2;

  always_comb begin
    sdNarrow = (vicReg == 8'd2) || (vicReg == 8'd6) ||
               (vicReg == 8'd17) || (vicReg == 8'd21);
    sdWide   = (vicReg == 8'd3) || (vicReg == 8'd7) ||
               (vicReg == 8'd18) || (vicReg == 8'd22);
    aspect   = sdNarrow ? ASP_4_3 : ASP_16_9;
    if (fmtReg == FMT_RGB)          colr = COLR_NONE;
    else if (sdNarrow || sdWide)    colr = COLR_SMPTE;
    else                            colr = COLR_BT709;
    pb1 = {1'b0, fmtReg, 1'b1, 4'h0};
    pb2 = {colr, aspect, 4'h8};
  end

  // raw packet content; checksum slot reads zero so it drops out of the sum
  logic [BYTE_W-1:0] rawByte;
  always_comb begin
    unique case (idx)
      IDX_W'(0): rawByte = HDR_TYPE;
      IDX_W'(1): rawByte = HDR_VER;
      IDX_W'(2): rawByte = HDR_LEN;
      IDX_PB1:   rawByte = pb1;
      IDX_PB2:   rawByte = pb2;
      IDX_VIC:   rawByte = vicReg;
      default:   rawByte = '0;
    endcase
  end

  always_comb begin
    outValid = ctrl.emit;
    outIndex = ctrl.emit ? idx : '0;
    if (!ctrl.emit)            outByte = '0;
    else if (idx == IDX_CSUM)  outByte = 8'h00 - sumReg;
    else                       outByte = rawByte;
    done = ctrl.finish;
  end
endmodule

// File: rtl/avi_pkt_builder.sv
module avi_pkt_builder
  import avi_pkt_pkg::*;
#(
  parameter int PKT_BYTES = 17,
  localparam int IDX_W    = $clog2(PKT_BYTES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [7:0]        vic,
  input  logic [1:0]        colorSel,
  output logic              busy,
  output logic              outValid,
  output logic [IDX_W-1:0]  outIndex,
  output logic [7:0]        outByte,
  output logic              done
);
  ctrl_t            ctrl;
  logic [IDX_W-1:0] idx;

  avi_pkt_ctrl #(.PKT_BYTES(PKT_BYTES), .IDX_W(IDX_W)) u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .start (start),
    .ctrl  (ctrl),
    .idx   (idx),
    .busy  (busy)
  );

  avi_pkt_dp #(.PKT_BYTES(PKT_BYTES), .IDX_W(IDX_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctrl     (ctrl),
    .idx      (idx),
    .vicIn    (vic),
    .colorIn  (colorSel),
    .outValid (outValid),
    .outIndex (outIndex),
    .outByte  (outByte),
    .done     (done)
  );
endmodule

// File: rtl/avi_pkt_builder_chk.sv
module avi_pkt_builder_chk #(
  parameter int PKT_BYTES = 17,
  parameter int IDX_W     = $clog2(PKT_BYTES)
) (
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic             busy,
  input logic             outValid,
  input logic [IDX_W-1:0] outIndex,
  input logic [7:0]       outByte,
  input logic             done
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(PKT_BYTES - 1);

  // R2
  hdr_type_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outIndex == '0) |-> outByte == 8'h82);

  // R10
  idx_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outIndex != '0) |-> ($past(outValid) && $past(outIndex) == outIndex - 1'b1));

  // R10
  valid_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> busy);

  // R11
  done_after_last_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> ($past(outValid) && $past(outIndex) == LAST));

  // R11
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (!done && !busy));

  // R10
  start_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> (busy && !outValid));

  // R11
  excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({outValid, done}));
endmodule

bind avi_pkt_builder avi_pkt_builder_chk #(.PKT_BYTES(PKT_BYTES), .IDX_W(IDX_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .start    (start),
  .busy     (busy),
  .outValid (outValid),
  .outIndex (outIndex),
  .outByte  (outByte),
  .done     (done)
);

// File: tb/avi_pkt_builder_bench.sv
module avi_pkt_builder_bench;
  logic       clk = 1'b0;
  logic       rstN;
  logic       start;
  logic [7:0] vic;
  logic [1:0] colorSel;
  logic       busy, outValid, done;
  logic [4:0] outIndex;
  logic [7:0] outByte;

  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  avi_pkt_builder u_avi_pkt_builder (
    .clk(clk), .rstN(rstN), .start(start), .vic(vic), .colorSel(colorSel),
    .busy(busy), .outValid(outValid), .outIndex(outIndex), .outByte(outByte),
    .done(done)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic bit isNarrow(input logic [7:0] v);
    return v == 2 || v == 6 || v == 17 || v == 21;
  endfunction
  function automatic bit isWide(input logic [7:0] v);
    return v == 3 || v == 7 || v == 18 || v == 22;
  endfunction

  function automatic logic [7:0] rawExp(input logic [7:0] v, input logic [1:0] c, input int i);
    logic [1:0] fmt, asp, col;
    fmt = (c == 2'd1) ? 2'd1 : (c == 2'd2) ? 2'd2 : 2'd0;
    asp = isNarrow(v) ? 2'd1 : 2'd2;
    if (fmt == 2'd0) col = 2'd0;
    else if (isNarrow(v) || isWide(v)) col = 2'd1;
    else col = 2'd2;
    case (i)
      0: return 8'h82;
      1: return 8'h02;
      2: return 8'h0D;
      4: return {1'b0, fmt, 1'b1, 4'h0};
      5: return {col, asp, 4'h8};
      7: return v;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] expByte(input logic [7:0] v, input logic [1:0] c, input int i);
    logic [7:0] s;
    if (i != 3) return rawExp(v, c, i);
    s = 8'h00;
    for (int k = 0; k < 17; k++) if (k != 3) s = s + rawExp(v, c, k);
    return 8'h00 - s;
  endfunction

  function automatic string tagFor(input logic [7:0] v, input logic [1:0] c, input int i);
    if (i < 3) return "R2";
    if (i == 3) return "R3";
    if (i == 4) return "R4";
    if (i == 5) begin
      if (c == 2'd0 || c == 2'd3) return "R8";
      if (isNarrow(v)) return "R5";
      if (isWide(v)) return "R6";
      return "R7";
    end
    return "R9";
  endfunction

  // junkSum / junkByte: cycle at which a stray start is injected (-1 none)
  task automatic runPkt(input logic [7:0] v, input logic [1:0] c,
                        input int junkSum, input int junkByte);
    int lat;
    logic [7:0] s;
    vic = v; colorSel = c; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!outValid && lat < 40) begin
      if (lat == junkSum) begin start = 1'b1; vic = ~v; colorSel = ~c; end
      else start = 1'b0;
      @(negedge clk);
      lat++;
    end
    start = 1'b0;
    chk(lat == 18, "R10 latency", lat, 18);
    s = 8'h00;
    for (int i = 0; i < 17; i++) begin
      if (i == junkByte) begin start = 1'b1; vic = v + 8'd1; colorSel = c + 2'd1; end
      else start = 1'b0;
      chk(outValid && outIndex == 5'(i), "R10 index", int'(outIndex), i);
      chk(outByte == expByte(v, c, i), tagFor(v, c, i), int'(outByte), int'(expByte(v, c, i)));
      s = s + outByte;
      @(negedge clk);
    end
    start = 1'b0;
    chk(s == 8'h00, "R3 zero-sum", int'(s), 0);
    chk(done && !outValid, "R11 done pulse", int'(done), 1);
    @(negedge clk);
    chk(!done && !busy, "R11 done drop", int'({done, busy}), 0);
    if (junkSum >= 0 || junkByte >= 0) begin
      @(negedge clk);
      chk(!busy && !outValid, "R12 no retrigger", int'({busy, outValid}), 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] sdList [8];
    sdList = '{8'd2, 8'd3, 8'd6, 8'd7, 8'd17, 8'd18, 8'd21, 8'd22};
    void'($urandom(32'd4242));
    rstN = 1'b0; start = 1'b0; vic = 8'd0; colorSel = 2'd0;
    repeat (3) @(negedge clk);
    start = 1'b1;
    chk(!busy && !outValid && !done, "R1 in reset", int'({busy, outValid, done}), 0);
    @(negedge clk);
    start = 1'b0;
    rstN = 1'b1;
    @(negedge clk);
    chk(!busy && !outValid && !done, "R1 after reset", int'({busy, outValid, done}), 0);

    // directed corners
    runPkt(8'd2,   2'd2, -1, -1);
    runPkt(8'd3,   2'd1, -1, -1);
    runPkt(8'd16,  2'd2, -1, -1);
    runPkt(8'd21,  2'd0, -1, -1);
    runPkt(8'd22,  2'd3, -1, -1);
    runPkt(8'd0,   2'd1,  5, -1);
    runPkt(8'd255, 2'd2, -1,  0);
    runPkt(8'd17,  2'd1,  2, 16);

    for (int n = 0; n < 60; n++) begin
      logic [7:0] v;
      logic [1:0] c;
      int js, jb;
      if ($urandom_range(0, 1) == 0) v = sdList[$urandom_range(0, 7)];
      else v = 8'($urandom_range(0, 255));
      c  = 2'($urandom_range(0, 3));
      js = ($urandom_range(0, 3) == 0) ? int'($urandom_range(2, 17)) : -1;
      jb = ($urandom_range(0, 3) == 0) ? int'($urandom_range(0, 16)) : -1;
      runPkt(v, c, js, jb);
      repeat ($urandom_range(0, 3)) @(negedge clk);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule